// File: doc/BRIEF.md
# Write-Only Control Byte Receiver for a Two-Wire Serial Bus

This block is the slave side of an I2C control link for an audio processor. It runs on a fast system clock and oversamples the bus clock and data lines through synchronizers. When a bus master opens a transfer with a START, the block shifts in the first byte and compares it with its device address. Six bits of that address are fixed by a parameter, and one bit comes from a strap pin. If the address matches and the transfer is a write, the block acknowledges each byte by enabling an open-drain pull-down on the data line during the ninth clock.

Every data byte that follows the address appears on a parallel output, together with a one-cycle valid strobe and a running byte index. The index starts at 0 for the first byte after the address. The block performs no reads and never stretches the clock. A STOP, or a START at any point, abandons the current byte and returns the block to address matching or to idle.

The system clock must run at least 20 times the bus clock rate (the bus runs at up to 100 kbit/s). This leaves the synchronizer and edge-detect latency well inside each quarter of a bus bit.

Top module: `cwr_slave`

## Requirements
- R1: During reset and directly after it, `sda_pull` and `rx_valid` are 0.
- R2: A START (SDA falling while SCL is high) is recognised at any point, including in the middle of a byte. It discards the partial byte, restarts address matching and sets the byte index of the next data byte to 0.
- R3: A STOP (SDA rising while SCL is high) ends the transfer and releases SDA. Bytes clocked after a STOP and before the next START produce no acknowledge and no strobe, and a byte cut short by a STOP produces no strobe.
- R4: Bits are taken at the rising edge of SCL, eight per byte with the MSB first, and a ninth clock for the acknowledge follows.
- R5: An address byte equal to 1,0,0,0,0,1,S,0 (MSB first, S = level of `addr_strap`, last bit = read/write with 0 meaning write) is acknowledged: `sda_pull` is 1 for the whole high phase of the ninth clock.
- R6: An address byte that differs in any bit, including read/write = 1, is not acknowledged. All following bytes of that transfer give no acknowledge and no strobe.
- R7: After a matched address, every data byte is acknowledged in its ninth clock.
- R8: Each data byte gives exactly one single-cycle `rx_valid` pulse, with the byte on `rx_data` and its position on `rx_index` (0 for the first byte after the address, then +1 per byte).
- R9: `sda_pull` changes only while the synchronized SCL is low. It is asserted before the ninth clock rises and released after that clock falls, except for release caused by START or STOP.
- R10: An SDA change that reaches the synchronizer in the same system-clock sample as an SCL rise is taken as a data bit and not as a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Strap level that sets the variable address bit |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on SDA |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte, valid with `rx_valid` |
| rx_index | output | IDX_W | Position of the byte after the address |

## Verification
The sharpest coincidence comes from the synchronizer: an SCL rise and an SDA change can arrive in the same sample. The edge detector must then shift a data bit and must not report a START or a STOP. The bench provokes this by moving both lines at the same clock edge for every bit of some transfers, both directed and random. It then judges that every byte still arrives intact, with its acknowledge and consecutive indices. The opposite coincidence is a START or STOP landing while a byte is half shifted. The bench provokes it with mid-byte aborts and mid-byte repeated STARTs, and judges that no strobe comes out of the broken byte and that the index restarts at 0.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      CWR_IDLE,
      CWR_RECV,
      CWR_ACK_SET,
      CWR_ACK_HOLD,
      CWR_SKIP
   } cwr_state_t;
endpackage

// File: rtl/cwr_line_sync.sv
module cwr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl,
   output logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_cond,
   output logic stop_cond
);
   localparam int LINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("cwr_line_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] raw;
   logic [LINES-1:0] cur;
   logic [LINES-1:0] prev;

   assign raw = {sda_raw, scl_raw};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-2:0], raw[g]};
      end
      assign cur[g] = pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= cur;
   end

   assign scl        = cur[0];
   assign sda        = cur[1];
   assign scl_rise   = cur[0] & ~prev[0];
   assign scl_fall   = ~cur[0] & prev[0];
   assign start_cond = cur[0] & prev[0] & prev[1] & ~cur[1];
   assign stop_cond  = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/cwr_addr_match.sv
module cwr_addr_match #(
   parameter logic [6:0] ADDR_BASE = 7'b1000010,
   parameter int         STRAP_POS = 1
) (
   input  logic [cwr_pkg::BYTE_W-1:0] rx_byte,
   input  logic                       strap,
   output logic                       hit
);
   localparam int BW = cwr_pkg::BYTE_W;

   if (STRAP_POS < 1 || STRAP_POS > BW - 1) begin : g_bad_pos
      $error("cwr_addr_match: STRAP_POS must select an address bit");
   end

   logic [BW-1:0] want;

   assign want[0] = 1'b0;
   for (genvar b = 1; b < BW; b++) begin : g_bit
      if (b == STRAP_POS) begin : g_strap
         assign want[b] = strap;
      end else begin : g_fixed
         assign want[b] = ADDR_BASE[b-1];
      end
   end

   assign hit = (rx_byte == want);
endmodule

// File: rtl/cwr_engine.sv
module cwr_engine #(
   parameter int IDX_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl,
   input  logic                       sda,
   input  logic                       scl_rise,
   input  logic                       scl_fall,
   input  logic                       start_cond,
   input  logic                       stop_cond,
   input  logic                       addr_hit,
   output logic [cwr_pkg::BYTE_W-1:0] byte_now,
   output logic                       sda_pull,
   output logic                       rx_valid,
   output logic [cwr_pkg::BYTE_W-1:0] rx_data,
   output logic [IDX_W-1:0]           rx_index
);
   import cwr_pkg::*;

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if (IDX_W < 1) begin : g_bad_idx
      $error("cwr_engine: IDX_W must be at least 1");
   end

   cwr_state_t        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              is_addr;

   assign byte_now = {shreg[BYTE_W-2:0], sda};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= CWR_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         is_addr  <= 1'b0;
         sda_pull <= 1'b0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         rx_index <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (start_cond) begin
            state    <= CWR_RECV;
            bit_cnt  <= '0;
            is_addr  <= 1'b1;
            sda_pull <= 1'b0;
            rx_index <= '0;
         end else if (stop_cond) begin
            state    <= CWR_IDLE;
            is_addr  <= 1'b0;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               CWR_RECV: begin
                  if (scl_rise) begin
                     shreg <= byte_now;
                     if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        if (is_addr) begin
                           state <= addr_hit ? CWR_ACK_SET : CWR_SKIP;
                        end else begin
                           rx_valid <= 1'b1;
                           rx_data  <= byte_now;
                           state    <= CWR_ACK_SET;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               CWR_ACK_SET: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b1;
                     state    <= CWR_ACK_HOLD;
                  end
               end
               CWR_ACK_HOLD: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     state    <= CWR_RECV;
                     is_addr  <= 1'b0;
                     if (!is_addr) rx_index <= rx_index + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_pull_rise_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl);
   assert_pull_fall_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_pull) && !$past(start_cond) && !$past(stop_cond)) |-> !scl);
   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   assert_strobe_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(scl_rise));
   assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_cond |=> (!sda_pull && !rx_valid));
   assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cond |=> !sda_pull);
endmodule

// File: rtl/cwr_slave.sv
module cwr_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter int         IDX_W       = 8,
   parameter logic [6:0] ADDR_BASE   = 7'b1000010,
   parameter int         STRAP_POS   = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_in,
   input  logic                       sda_in,
   input  logic                       addr_strap,
   output logic                       sda_pull,
   output logic                       rx_valid,
   output logic [cwr_pkg::BYTE_W-1:0] rx_data,
   output logic [IDX_W-1:0]           rx_index
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_cond, stop_cond, addr_hit;
   logic [cwr_pkg::BYTE_W-1:0] byte_now;

   cwr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_raw    (scl_in),
      .sda_raw    (sda_in),
      .scl        (scl_s),
      .sda        (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_cond (start_cond),
      .stop_cond  (stop_cond)
   );

   cwr_addr_match #(.ADDR_BASE(ADDR_BASE), .STRAP_POS(STRAP_POS)) u_match (
      .rx_byte (byte_now),
      .strap   (addr_strap),
      .hit     (addr_hit)
   );

   cwr_engine #(.IDX_W(IDX_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl        (scl_s),
      .sda        (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_cond (start_cond),
      .stop_cond  (stop_cond),
      .addr_hit   (addr_hit),
      .byte_now   (byte_now),
      .sda_pull   (sda_pull),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_index   (rx_index)
   );
endmodule

// File: tb/cwr_slave_bench.sv
module cwr_slave_bench;
   localparam int Q = 8;
   localparam int LOGN = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic strap = 1'b0;
   logic sda_pull, rx_valid;
   logic [7:0] rx_data;
   logic [7:0] rx_index;
   logic sda_line;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] log_d [LOGN];
   logic [7:0] log_i [LOGN];
   int log_n = 0;
   logic [7:0] tx_buf [16];
   int tx_len = 0;

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull;

   cwr_slave u_cwr_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (m_scl),
      .sda_in     (sda_line),
      .addr_strap (strap),
      .sda_pull   (sda_pull),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_index   (rx_index)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         log_d[log_n % LOGN] = rx_data;
         log_i[log_n % LOGN] = rx_index;
         log_n = log_n + 1;
      end
   end

   function automatic logic [7:0] exp_addr(input logic s);
      return {6'b100001, s, 1'b0};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b, input bit skew);
      if (skew) begin
         wq();
         m_sda = b; m_scl = 1'b1;
      end else begin
         m_sda = b; wq();
         m_scl = 1'b1;
      end
      wq(); wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit skew, output bit acked, output bit early);
      for (int i = 7; i >= 0; i--) send_bit(b[i], skew);
      m_sda = 1'b1; wq();
      early = sda_pull;
      m_scl = 1'b1; wq();
      acked = sda_pull;
      wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic run_xfer(input logic [7:0] adr, input bit exp_ack, input bit do_stop,
                           input bit skew, input string req);
      int base;
      bit a, e;
      base = log_n;
      bus_start();
      send_byte(adr, skew, a, e);
      chk(a == exp_ack, exp_ack ? {"R5 addr ack ", req} : {"R6 addr nack ", req}, a, exp_ack);
      for (int i = 0; i < tx_len; i++) begin
         send_byte(tx_buf[i], skew, a, e);
         chk(a == exp_ack, exp_ack ? {"R7 data ack ", req} : {"R6 data ignored ", req}, a, exp_ack);
         if (exp_ack) chk(e == 1'b1, {"R9 pull before ninth rise ", req}, e, 1);
      end
      if (do_stop) bus_stop();
      repeat (4) @(negedge clk);
      chk((log_n - base) == (exp_ack ? tx_len : 0), {"R8 strobe count ", req},
          log_n - base, exp_ack ? tx_len : 0);
      if (exp_ack) begin
         for (int i = 0; i < tx_len; i++) begin
            chk(log_d[(base + i) % LOGN] == tx_buf[i], {"R4 byte value ", req},
                log_d[(base + i) % LOGN], tx_buf[i]);
            chk(log_i[(base + i) % LOGN] == 8'(i), {"R8 byte index ", req},
                log_i[(base + i) % LOGN], i);
         end
      end
   endtask

   initial begin
      int base;
      bit a, e;
      logic [7:0] adr;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      chk(sda_pull == 1'b0 && rx_valid == 1'b0, "R1 in reset", {sda_pull, rx_valid}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_pull == 1'b0 && rx_valid == 1'b0, "R1 after reset", {sda_pull, rx_valid}, 0);

      strap = 1'b0;
      tx_buf[0] = 8'hA5; tx_buf[1] = 8'h00; tx_buf[2] = 8'hFF; tx_len = 3;
      run_xfer(exp_addr(1'b0), 1'b1, 1'b1, 1'b0, "strap0 match");

      strap = 1'b1;
      tx_buf[0] = 8'h3C; tx_buf[1] = 8'h81; tx_len = 2;
      run_xfer(exp_addr(1'b1), 1'b1, 1'b1, 1'b0, "strap1 match");
      run_xfer(exp_addr(1'b0), 1'b0, 1'b1, 1'b0, "strap bit wrong");
      run_xfer(exp_addr(1'b1) | 8'h01, 1'b0, 1'b1, 1'b0, "read bit set");
      run_xfer(exp_addr(1'b1) ^ 8'h40, 1'b0, 1'b1, 1'b0, "fixed bit wrong");

      // R2: repeated START without STOP restarts index
      tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_len = 2;
      run_xfer(exp_addr(1'b1), 1'b1, 1'b0, 1'b0, "before repeated start");
      tx_buf[0] = 8'h33; tx_buf[1] = 8'h44; tx_len = 2;
      run_xfer(exp_addr(1'b1), 1'b1, 1'b1, 1'b0, "R2 after repeated start");

      // R3: bytes after STOP without a START are ignored
      base = log_n;
      m_scl = 1'b0; wq();
      send_byte(exp_addr(1'b1), 1'b0, a, e);
      chk(a == 1'b0, "R3 no ack after stop", a, 0);
      send_byte(8'h5A, 1'b0, a, e);
      chk(a == 1'b0, "R3 no data ack after stop", a, 0);
      bus_stop();
      repeat (4) @(negedge clk);
      chk(log_n == base, "R3 no strobe after stop", log_n - base, 0);

      // R3: STOP in the middle of a data byte
      base = log_n;
      bus_start();
      send_byte(exp_addr(1'b1), 1'b0, a, e);
      chk(a == 1'b1, "R5 addr ack before abort", a, 1);
      for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
      bus_stop();
      repeat (4) @(negedge clk);
      chk(log_n == base && sda_pull == 1'b0, "R3 aborted byte gives no strobe", log_n - base, 0);

      // R2: START in the middle of a data byte
      base = log_n;
      bus_start();
      send_byte(exp_addr(1'b1), 1'b0, a, e);
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
      chk(log_n == base, "R2 partial byte gives no strobe", log_n - base, 0);
      tx_buf[0] = 8'hC3; tx_buf[1] = 8'h7E; tx_len = 2;
      run_xfer(exp_addr(1'b1), 1'b1, 1'b1, 1'b0, "R2 mid-byte start");

      // R10: SDA and SCL move in the same sample
      strap = 1'b0;
      tx_buf[0] = 8'h96; tx_buf[1] = 8'h69; tx_buf[2] = 8'h0F; tx_len = 3;
      run_xfer(exp_addr(1'b0), 1'b1, 1'b1, 1'b1, "R10 skewed edges");

      for (int t = 0; t < 40; t++) begin
         bit good, sk;
         strap = 1'($urandom_range(0, 1));
         good = ($urandom_range(0, 3) != 0);
         sk = 1'($urandom_range(0, 1));
         adr = exp_addr(strap);
         if (!good) begin
            adr = 8'($urandom_range(0, 255));
            if (adr == exp_addr(strap)) adr = adr ^ 8'h01;
         end
         tx_len = $urandom_range(0, 5);
         for (int i = 0; i < tx_len; i++) tx_buf[i] = 8'($urandom_range(0, 255));
         run_xfer(adr, good, 1'($urandom_range(0, 3) != 0), sk,
                  sk ? "random R10 skewed" : "random");
      end
      bus_stop();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule